// File: doc/BRIEF.md
# Radio Byte FIFO Port

This block sits between a processor and a radio datapath and gives both of them one 8-bit data register to work through. A processor write to that register appends the byte to a 128-entry transmit queue. A processor read of the same register takes the oldest byte out of a separate 128-entry receive queue. On the radio side, the transmit queue is drained through a valid/ready byte stream, and incoming bytes fill the receive queue through a second valid/ready byte stream.

Only the receive queue is described by status outputs: one flag for not-empty and one for above a programmable threshold. A one-cycle DMA request marks the moment the receive queue first holds data. Each queue has its own single-cycle flush strobe. Sticky flags record dropped writes and empty reads. An 8-bit interrupt flag bank collects event pulses; the rise of the receive threshold flag is one of those events. Each flag is cleared by writing a 1 to it, and a per-bit mask gates the flags onto a single interrupt line.

Top module: `radio_byte_port`

## Requirements
- R1: After reset, cpu_rdata is 0x00, tx_valid, rx_nonempty, rx_above, dma_req, tx_ovf, rx_udf and irq are all 0, and irq_flags is 0x00.
- R2: Each cpu_wr cycle appends cpu_wdata to the transmit queue. tx_valid is high whenever that queue holds data. tx_data shows the oldest byte, and a cycle with tx_valid and tx_ready both high removes that byte, so bytes leave in the order they were written.
- R3: A cycle with rx_valid and rx_ready both high appends rx_data to the receive queue. A cpu_rd cycle on a non-empty queue removes the oldest byte and places it on cpu_rdata one clock later. cpu_rdata holds that value until the next read.
- R4: Each queue holds 128 bytes. A cpu_wr while the transmit queue is full is dropped and sets the sticky tx_ovf. rx_ready is low while the receive queue is full.
- R5: A cpu_rd while the receive queue is empty loads 0x00 into cpu_rdata, removes nothing and sets the sticky rx_udf. A byte pushed afterwards is the next byte read.
- R6: flush_tx empties only the transmit queue and clears tx_ovf. flush_rx empties only the receive queue and clears rx_udf. A radio byte that arrives in the same cycle as flush_rx is discarded.
- R7: rx_nonempty is high when the receive queue holds at least one byte. rx_above is high when the receive byte count is strictly greater than rx_thresh. Neither flag depends on the transmit queue.
- R8: dma_req is a one-cycle pulse in the first cycle the receive queue is non-empty after having been empty.
- R9: irq_flags bit i is set one clock after a pulse on source i. It is cleared by a cycle with irq_clr bit i high, and a set in the same cycle wins over the clear. Source 5 is the rising edge of rx_above, and irq_ev bit 5 is ignored. The other sources are the matching irq_ev bits.
- R10: irq is high exactly when some bit is set in both irq_flags and irq_mask. With irq_mask at 0x00, irq is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_wr | input | 1 | Processor write strobe of the data register |
| cpu_wdata | input | 8 | Byte to append to the transmit queue |
| cpu_rd | input | 1 | Processor read strobe of the data register |
| cpu_rdata | output | 8 | Data register read value |
| flush_tx | input | 1 | Empty the transmit queue |
| flush_rx | input | 1 | Empty the receive queue |
| tx_valid | output | 1 | Transmit queue has a byte for the radio |
| tx_data | output | 8 | Oldest transmit byte |
| tx_ready | input | 1 | Radio takes the transmit byte |
| rx_valid | input | 1 | Radio offers a received byte |
| rx_data | input | 8 | Received byte |
| rx_ready | output | 1 | Receive queue has room |
| rx_thresh | input | 8 | Receive count threshold |
| rx_nonempty | output | 1 | Receive queue holds data |
| rx_above | output | 1 | Receive count above rx_thresh |
| dma_req | output | 1 | One-cycle DMA request on receive empty-to-non-empty |
| tx_ovf | output | 1 | Sticky: a write was dropped on a full transmit queue |
| rx_udf | output | 1 | Sticky: a read hit an empty receive queue |
| irq_ev | input | 8 | Event pulses for the interrupt sources |
| irq_clr | input | 8 | Write-1-to-clear for the interrupt flags |
| irq_mask | input | 8 | Interrupt enable per flag |
| irq_flags | output | 8 | Pending interrupt flags |
| irq | output | 1 | Masked interrupt line |

## Verification
The assertions check on every cycle that dma_req never lasts two cycles and only appears while data is present. They also check that each flush leaves its own queue empty on the next cycle, that an empty read yields 0x00 and sets rx_udf, that a write into a full transmit queue sets tx_ovf, that rx_above implies rx_nonempty, and that a zero mask keeps irq low. Only the directed scenarios can show byte ordering through both queues, the exact 128-byte capacity, isolation of the two flushes from each other, the flush-over-arrival priority, the threshold-edge interrupt source with its ignored external bit, and set-over-clear priority on the flags.

// File: rtl/rbp_pkg.sv
package rbp_pkg;

  // Next occupancy of a queue given the accepted push and pop of this cycle.
  function automatic int unsigned f_count_next(input int unsigned cnt,
                                               input logic push,
                                               input logic pop,
                                               input logic flush);
    int unsigned n;
    if (flush) return 0;
    n = cnt;
    if (push) n = n + 1;
    if (pop)  n = n - 1;
    return n;
  endfunction

  // Threshold comparison: strictly greater than.
  function automatic logic f_above(input int unsigned cnt, input int unsigned thr);
    return cnt > thr;
  endfunction

  // Next value of a flag: a set wins over a write-1 clear.
  function automatic logic f_flag_next(input logic cur, input logic set, input logic clr);
    return set | (cur & ~clr);
  endfunction

endpackage

// File: rtl/rbp_fifo.sv
module rbp_fifo #(
  parameter int DW    = 8,
  parameter int DEPTH = 128
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         flush,
  input  logic                         push,
  input  logic [DW-1:0]                wdata,
  input  logic                         pop,
  output logic [DW-1:0]                head,
  output logic [$clog2(DEPTH+1)-1:0]   count,
  output logic                         full,
  output logic                         empty
);
  import rbp_pkg::*;

  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH+1);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic          do_push, do_pop;

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign do_push = push & ~full & ~flush;
  assign do_pop  = pop & ~empty & ~flush;
  assign head    = mem[rptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wptr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (flush) begin
        wptr <= '0;
        rptr <= '0;
      end else begin
        if (do_push) wptr <= (wptr == AW'(DEPTH-1)) ? '0 : wptr + 1'b1;
        if (do_pop)  rptr <= (rptr == AW'(DEPTH-1)) ? '0 : rptr + 1'b1;
      end
      count <= CW'(f_count_next(32'(count), do_push, do_pop, flush));
    end
  end

endmodule

// File: rtl/rbp_irq.sv
module rbp_irq #(
  parameter int NSRC = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] ev,
  input  logic [NSRC-1:0] clr,
  input  logic [NSRC-1:0] mask,
  output logic [NSRC-1:0] flags,
  output logic            irq
);
  import rbp_pkg::*;

  for (genvar i = 0; i < NSRC; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flags[i] <= 1'b0;
      else        flags[i] <= f_flag_next(flags[i], ev[i], clr[i]);
    end
  end

  assign irq = |(flags & mask);

endmodule

// File: rtl/radio_byte_port.sv
module radio_byte_port #(
  parameter int DW      = 8,
  parameter int DEPTH   = 128,
  parameter int NSRC    = 8,
  parameter int THR_BIT = 5
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cpu_wr,
  input  logic [DW-1:0]              cpu_wdata,
  input  logic                       cpu_rd,
  output logic [DW-1:0]              cpu_rdata,
  input  logic                       flush_tx,
  input  logic                       flush_rx,
  output logic                       tx_valid,
  output logic [DW-1:0]              tx_data,
  input  logic                       tx_ready,
  input  logic                       rx_valid,
  input  logic [DW-1:0]              rx_data,
  output logic                       rx_ready,
  input  logic [$clog2(DEPTH+1)-1:0] rx_thresh,
  output logic                       rx_nonempty,
  output logic                       rx_above,
  output logic                       dma_req,
  output logic                       tx_ovf,
  output logic                       rx_udf,
  input  logic [NSRC-1:0]            irq_ev,
  input  logic [NSRC-1:0]            irq_clr,
  input  logic [NSRC-1:0]            irq_mask,
  output logic [NSRC-1:0]            irq_flags,
  output logic                       irq
);
  import rbp_pkg::*;

  localparam int CW = $clog2(DEPTH+1);

  logic [CW-1:0] tx_cnt, rx_cnt;
  logic          tx_full, tx_empty, rx_full, rx_empty;
  logic [DW-1:0] rx_head;
  logic          nonempty_q, above_q;

  // named internal events
  logic          tx_drop_ev, rx_under_ev, rx_first_ev, thr_rise_ev;
  logic          rx_accept;
  logic [NSRC-1:0] src_ev;

  rbp_fifo #(.DW(DW), .DEPTH(DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n), .flush(flush_tx),
    .push(cpu_wr), .wdata(cpu_wdata),
    .pop(tx_ready), .head(tx_data),
    .count(tx_cnt), .full(tx_full), .empty(tx_empty)
  );

  assign rx_accept = rx_valid & ~rx_full;

  rbp_fifo #(.DW(DW), .DEPTH(DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n), .flush(flush_rx),
    .push(rx_accept), .wdata(rx_data),
    .pop(cpu_rd), .head(rx_head),
    .count(rx_cnt), .full(rx_full), .empty(rx_empty)
  );

  assign tx_valid    = ~tx_empty;
  assign rx_ready    = ~rx_full;
  assign rx_nonempty = ~rx_empty;
  assign rx_above    = f_above(32'(rx_cnt), 32'(rx_thresh));

  assign tx_drop_ev  = cpu_wr & tx_full & ~flush_tx;
  assign rx_under_ev = cpu_rd & rx_empty & ~flush_rx;
  assign rx_first_ev = rx_nonempty & ~nonempty_q;
  assign thr_rise_ev = rx_above & ~above_q;
  assign dma_req     = rx_first_ev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cpu_rdata  <= '0;
      nonempty_q <= 1'b0;
      above_q    <= 1'b0;
      tx_ovf     <= 1'b0;
      rx_udf     <= 1'b0;
    end else begin
      nonempty_q <= rx_nonempty;
      above_q    <= rx_above;
      if (cpu_rd) cpu_rdata <= rx_empty ? '0 : rx_head;
      tx_ovf <= flush_tx ? 1'b0 : (tx_ovf | tx_drop_ev);
      rx_udf <= flush_rx ? 1'b0 : (rx_udf | rx_under_ev);
    end
  end

  always_comb begin
    src_ev          = irq_ev;
    src_ev[THR_BIT] = thr_rise_ev;
  end

  rbp_irq #(.NSRC(NSRC)) u_irq (
    .clk(clk), .rst_n(rst_n), .ev(src_ev), .clr(irq_clr),
    .mask(irq_mask), .flags(irq_flags), .irq(irq)
  );

endmodule

// File: rtl/rbp_chk.sv
module rbp_chk #(
  parameter int DW   = 8,
  parameter int NSRC = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cpu_wr,
  input logic            cpu_rd,
  input logic            flush_tx,
  input logic            flush_rx,
  input logic            tx_full,
  input logic            tx_valid,
  input logic            rx_nonempty,
  input logic            rx_above,
  input logic            dma_req,
  input logic            tx_ovf,
  input logic            rx_udf,
  input logic [DW-1:0]   cpu_rdata,
  input logic [NSRC-1:0] irq_mask,
  input logic            irq
);

  // R8
  dma_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req |=> !dma_req);

  // R8
  dma_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req |-> rx_nonempty);

  // R6
  flush_tx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush_tx |=> !tx_valid && !tx_ovf);

  // R6
  flush_rx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush_rx |=> !rx_nonempty && !rx_udf);

  // R5
  empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_rd && !rx_nonempty && !flush_rx) |=> rx_udf && (cpu_rdata == '0));

  // R4
  tx_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && tx_full && !flush_tx) |=> tx_ovf);

  // R7
  above_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_above |-> rx_nonempty);

  // R10
  mask_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_mask == '0) |-> !irq);

endmodule

bind radio_byte_port rbp_chk #(.DW(DW), .NSRC(NSRC)) u_rbp_chk (
  .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd),
  .flush_tx(flush_tx), .flush_rx(flush_rx), .tx_full(tx_full),
  .tx_valid(tx_valid), .rx_nonempty(rx_nonempty), .rx_above(rx_above),
  .dma_req(dma_req), .tx_ovf(tx_ovf), .rx_udf(rx_udf),
  .cpu_rdata(cpu_rdata), .irq_mask(irq_mask), .irq(irq)
);

// File: tb/test_radio_byte_port.sv
module test_radio_byte_port;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cpu_wr = 0, cpu_rd = 0, flush_tx = 0, flush_rx = 0;
  logic [7:0] cpu_wdata = 0, rx_data = 0, rx_thresh = 8'd200;
  logic       tx_ready = 0, rx_valid = 0;
  logic [7:0] irq_ev = 0, irq_clr = 0, irq_mask = 0;
  logic [7:0] cpu_rdata, tx_data, irq_flags;
  logic       tx_valid, rx_ready, rx_nonempty, rx_above, dma_req, tx_ovf, rx_udf, irq;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #2 clk = ~clk;

  radio_byte_port i_radio_byte_port (
    .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata),
    .cpu_rd(cpu_rd), .cpu_rdata(cpu_rdata), .flush_tx(flush_tx), .flush_rx(flush_rx),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
    .rx_thresh(rx_thresh), .rx_nonempty(rx_nonempty), .rx_above(rx_above),
    .dma_req(dma_req), .tx_ovf(tx_ovf), .rx_udf(rx_udf),
    .irq_ev(irq_ev), .irq_clr(irq_clr), .irq_mask(irq_mask),
    .irq_flags(irq_flags), .irq(irq)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic cpu_write(input logic [7:0] b);
    @(negedge clk); cpu_wr = 1; cpu_wdata = b;
    @(negedge clk); cpu_wr = 0;
  endtask

  task automatic cpu_read(output logic [7:0] b);
    @(negedge clk); cpu_rd = 1;
    @(negedge clk); cpu_rd = 0; b = cpu_rdata;
  endtask

  task automatic rx_push(input logic [7:0] b);
    @(negedge clk); rx_valid = 1; rx_data = b;
    @(negedge clk); rx_valid = 0;
  endtask

  task automatic tx_pop(output logic [7:0] b, output logic v);
    @(negedge clk); v = tx_valid; b = tx_data; tx_ready = 1;
    @(negedge clk); tx_ready = 0;
  endtask

  task automatic pulse_flush(input bit tx, input bit rx);
    @(negedge clk); flush_tx = tx; flush_rx = rx;
    @(negedge clk); flush_tx = 0; flush_rx = 0;
  endtask

  task automatic t_reset();
    chk(cpu_rdata == 0, "R1 rdata", cpu_rdata, 0);
    chk({tx_valid, rx_nonempty, rx_above, dma_req, tx_ovf, rx_udf, irq} == 0,
        "R1 status", {tx_valid, rx_nonempty, rx_above, dma_req, tx_ovf, rx_udf, irq}, 0);
    chk(irq_flags == 0, "R1 flags", irq_flags, 0);
  endtask

  task automatic t_tx_order();
    logic [7:0] b; logic v;
    cpu_write(8'hA1); cpu_write(8'hB2); cpu_write(8'hC3);
    chk(tx_valid, "R2 valid", tx_valid, 1);
    chk(!rx_nonempty, "R7 tx-only", rx_nonempty, 0);
    tx_pop(b, v); chk(v && b == 8'hA1, "R2 first", b, 8'hA1);
    tx_pop(b, v); chk(v && b == 8'hB2, "R2 second", b, 8'hB2);
    tx_pop(b, v); chk(v && b == 8'hC3, "R2 third", b, 8'hC3);
    chk(!tx_valid, "R2 drained", tx_valid, 0);
  endtask

  task automatic t_rx_order();
    logic [7:0] b;
    rx_push(8'h11);
    chk(dma_req, "R8 pulse", dma_req, 1);
    chk(rx_nonempty, "R7 nonempty", rx_nonempty, 1);
    @(negedge clk);
    chk(!dma_req, "R8 one cycle", dma_req, 0);
    rx_push(8'h22);
    chk(!dma_req, "R8 no repeat", dma_req, 0);
    rx_push(8'h33);
    cpu_read(b); chk(b == 8'h11, "R3 first", b, 8'h11);
    @(negedge clk); chk(cpu_rdata == 8'h11, "R3 hold", cpu_rdata, 8'h11);
    cpu_read(b); chk(b == 8'h22, "R3 second", b, 8'h22);
    cpu_read(b); chk(b == 8'h33, "R3 third", b, 8'h33);
    chk(!rx_nonempty, "R7 empty", rx_nonempty, 0);
  endtask

  task automatic t_underflow();
    logic [7:0] b;
    cpu_read(b);
    chk(b == 0, "R5 zero", b, 0);
    chk(rx_udf, "R5 sticky", rx_udf, 1);
    rx_push(8'h5A);
    cpu_read(b);
    chk(b == 8'h5A, "R5 pointers", b, 8'h5A);
    chk(rx_udf, "R5 still set", rx_udf, 1);
    pulse_flush(0, 1);
    chk(!rx_udf, "R6 udf cleared", rx_udf, 0);
  endtask

  task automatic t_tx_full();
    logic [7:0] b; logic v; bit ok = 1;
    for (int i = 0; i < 128; i++) cpu_write(8'(i + 3));
    chk(!tx_ovf, "R4 no drop at 128", tx_ovf, 0);
    cpu_write(8'hEE);
    chk(tx_ovf, "R4 overflow", tx_ovf, 1);
    for (int i = 0; i < 128; i++) begin
      tx_pop(b, v);
      if (!v || b != 8'(i + 3)) begin
        ok = 0;
        chk(0, "R4 content", b, i + 3);
      end
    end
    chk(ok && !tx_valid, "R4 exactly 128", tx_valid, 0);
    pulse_flush(1, 0);
    chk(!tx_ovf, "R6 ovf cleared", tx_ovf, 0);
  endtask

  task automatic t_rx_full_flush();
    logic [7:0] b;
    for (int i = 0; i < 128; i++) rx_push(8'(i));
    chk(!rx_ready, "R4 rx full", rx_ready, 0);
    cpu_write(8'h77);
    pulse_flush(1, 0);
    chk(rx_nonempty && !rx_ready, "R6 tx flush keeps rx", rx_nonempty, 1);
    cpu_read(b);
    chk(b == 8'h00, "R6 rx order after tx flush", b, 0);
    cpu_write(8'h66);
    pulse_flush(0, 1);
    chk(!rx_nonempty && tx_valid && tx_data == 8'h66, "R6 rx flush keeps tx", tx_data, 8'h66);
    @(negedge clk); flush_rx = 1; rx_valid = 1; rx_data = 8'h99;
    @(negedge clk); flush_rx = 0; rx_valid = 0;
    chk(!rx_nonempty, "R6 flush wins", rx_nonempty, 0);
    pulse_flush(1, 0);
  endtask

  task automatic t_thresh_irq();
    rx_thresh = 8'd2;
    rx_push(8'h01); rx_push(8'h02);
    chk(!rx_above, "R7 at threshold", rx_above, 0);
    rx_push(8'h03);
    chk(rx_above, "R7 above", rx_above, 1);
    @(negedge clk);
    chk(irq_flags == 8'h20, "R9 threshold source", irq_flags, 8'h20);
    chk(!irq, "R10 masked", irq, 0);
    irq_mask = 8'h20; #0;
    chk(irq, "R10 enabled", irq, 1);
    @(negedge clk); irq_clr = 8'h20;
    @(negedge clk); irq_clr = 0;
    chk(irq_flags == 0 && !irq, "R9 clear", irq_flags, 0);
    @(negedge clk); irq_ev = 8'h24;
    @(negedge clk); irq_ev = 0;
    chk(irq_flags == 8'h04, "R9 ext bit5 ignored", irq_flags, 8'h04);
    chk(!irq, "R10 other bit masked", irq, 0);
    @(negedge clk); irq_ev = 8'h02; irq_clr = 8'h02;
    @(negedge clk); irq_ev = 0; irq_clr = 0;
    chk(irq_flags[1], "R9 set wins", irq_flags, 8'h06);
    irq_mask = 8'h02; #0;
    chk(irq, "R10 bit1", irq, 1);
    pulse_flush(0, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_tx_order();
    t_rx_order();
    t_underflow();
    t_tx_full();
    t_rx_full_flush();
    t_thresh_irq();
    done = 1;
  end

  initial begin
    for (int c = 0; c < 200000 && !done; c++) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=done");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule